// File: doc/BRIEF.md
# Wide-Bus Send Byte Pairing

This block turns a stream of bytes from memory into 16-bit words for a wide parallel bus while data is being sent. Each send is started as a move with a byte count and a chaining qualifier. Within a move, bytes are paired in arrival order: the earlier byte goes in the low half of the word and the later byte in the high half. Each finished word is offered on a valid/ready output.

When a chained move ends on an odd byte, that last byte is not sent. It is parked in the low half of the output latch and a residue flag goes high. The first byte of the next send, whether that move is chained or plain, becomes the high half of a word that carries the parked byte. The flag drops once the bus side accepts that word. A plain move that ends on an odd byte sends its last word half-filled instead: the high byte is zero and a half-word marker is raised.

Software can read the residue flag and can clear it. Clearing the flag throws the parked byte away, so the next move pairs its own bytes from the start.

Top module: `wide_pair_send`

## Requirements
- R1: While reset is asserted and after reset is released, `pend_flag`, `out_valid`, `in_ready` and `xfer_busy` are 0, and no byte is held.
- R2: Within a move, the first byte of each pair appears on `out_data[7:0]` and the second byte on `out_data[15:8]`, with `out_half` at 0.
- R3: A start pulse with a nonzero count, given while `xfer_busy` is 0, makes the block accept exactly that many bytes. `xfer_busy` stays 1 while bytes remain or a word waits on the output. A start given while busy is ignored. `in_ready` is 0 whenever the block is not busy.
- R4: When a plain (`xfer_chained`=0) move ends on an odd byte, that byte is sent as a word with `out_data[15:8]`=0 and `out_half`=1.
- R5: When a chained move ends on an odd byte, no word is sent for that byte, the byte is held, and `pend_flag` becomes 1.
- R6: `pend_flag` rises only at the last byte of a chained move. A plain move never sets it.
- R7: While `pend_flag` is 1, the first byte of the next move, plain or chained, is sent as `out_data[15:8]` with the held byte as `out_data[7:0]`. That byte counts toward the new move's count.
- R8: `pend_flag` returns to 0 in the cycle after the bus accepts the paired word, unless that same move sets it again.
- R9: A `pend_clr` pulse clears `pend_flag` in the next cycle and discards the held byte. The next move then pairs its own first and second bytes.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_half` do not change.
- R11: A start pulse with a count of 0 has no effect: no byte is accepted, no word is sent, and `pend_flag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| xfer_start | input | 1 | One-cycle request to begin a move |
| xfer_count | input | 12 | Byte count of the move |
| xfer_chained | input | 1 | 1 marks the move as chained |
| xfer_busy | output | 1 | A move is in progress or a word is still waiting on the output |
| in_data | input | 8 | Byte from memory |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | The block takes the byte in this cycle |
| out_data | output | 16 | Word for the bus |
| out_half | output | 1 | Only the low byte of `out_data` is meaningful |
| out_valid | output | 1 | `out_data` is valid |
| out_ready | input | 1 | The bus takes the word in this cycle |
| pend_flag | output | 1 | A byte from a chained move is parked and waiting for a partner |
| pend_clr | input | 1 | Software clear of the flag and the parked byte |

## Verification
The hardest state to reach from the ports is a paired word that is still waiting for acceptance while the new move's next byte arrives and itself ends another chained move. In that cycle the automatic clear and a fresh set of the flag fall together. The stimulus reaches this with back-to-back one- and two-byte chained moves. It also holds output readiness low for long stretches and then releases it, so words stack up behind the paired word. A randomized phase mixes move lengths from zero to nine, both qualifiers, idle-time clears and varied ready and valid densities. A cycle-accurate model follows every cycle, and directed word lists check the pairing order separately.

// File: rtl/wps_pkg.sv
package wps_pkg;

  // what the pairing stage hands to the output word register in a cycle
  typedef enum logic [1:0] {
    EMIT_NONE = 2'd0,
    EMIT_FULL = 2'd1,
    EMIT_HALF = 2'd2
  } emit_e;

endpackage

// File: rtl/wps_rst_sync.sv
module wps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/wps_byte_counter.sv
module wps_byte_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_chained,
  input  logic             dec,
  output logic             rem_zero,
  output logic             rem_last,
  output logic             chained
);

  logic [CNT_W-1:0] rem_q, rem_d;
  logic             chain_q, chain_d;
  logic             cnt_en;

  always_comb begin
    rem_d   = rem_q;
    chain_d = chain_q;
    cnt_en  = load | dec;
    if (load) begin
      rem_d   = load_cnt;
      chain_d = load_chained;
    end else if (dec) begin
      rem_d   = rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      chain_q <= 1'b0;
    end else if (cnt_en) begin
      rem_q   <= rem_d;
      chain_q <= chain_d;
    end
  end

  assign rem_zero = (rem_q == '0);
  assign rem_last = (rem_q == CNT_W'(1));
  assign chained  = chain_q;

  // every accepted byte takes exactly one off the remaining count
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (rem_q == CNT_W'($past(rem_q) - CNT_W'(1)))) else $error("AST_REM_STEP"); // R3

  // a new count is taken only from the idle state
  AST_LOAD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> rem_zero) else $error("AST_LOAD_FROM_IDLE"); // R3

endmodule

// File: rtl/wps_pair_unit.sv
module wps_pair_unit
  import wps_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              last_byte,
  input  logic              chained,
  input  logic              sw_clr,
  input  logic              pair_acc,
  output emit_e             emit,
  output logic [BYTE_W-1:0] word_hi,
  output logic [BYTE_W-1:0] word_lo,
  output logic              word_paired,
  output logic              pend
);

  logic [BYTE_W-1:0] hold_q;
  logic              have_q, have_d;
  logic              pend_q, pend_d;
  logic              hold_en;
  logic              set_pend;

  always_comb begin
    emit        = EMIT_NONE;
    word_hi     = '0;
    word_lo     = hold_q;
    word_paired = 1'b0;
    have_d      = have_q;
    hold_en     = 1'b0;
    set_pend    = 1'b0;
    if (fire) begin
      if (have_q) begin
        emit        = EMIT_FULL;
        word_hi     = in_byte;
        word_lo     = hold_q;
        word_paired = pend_q;
        have_d      = 1'b0;
      end else if (last_byte && chained) begin
        set_pend = 1'b1;
        have_d   = 1'b1;
        hold_en  = 1'b1;
      end else if (last_byte) begin
        emit    = EMIT_HALF;
        word_lo = in_byte;
      end else begin
        have_d  = 1'b1;
        hold_en = 1'b1;
      end
    end
    // software clear drops a parked byte, never a partner byte of the running move
    if (sw_clr && (set_pend || (pend_q && have_q))) begin
      have_d = 1'b0;
    end
  end

  always_comb begin
    if (sw_clr) begin
      pend_d = 1'b0;
    end else if (set_pend) begin
      pend_d = 1'b1;
    end else if (pair_acc) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      have_q <= have_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= in_byte;
    end
  end

  assign pend = pend_q;

  AST_PEND_ONLY_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(fire && last_byte && chained)) else $error("AST_PEND_ONLY_CHAINED"); // R6

  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> !pend_q) else $error("AST_SW_CLEAR"); // R9

  AST_PEND_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !have_q) |-> $past(fire || pend_q)) else $error("AST_PEND_KEEPS_BYTE"); // R7

endmodule

// File: rtl/wps_word_reg.sv
module wps_word_reg #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [BYTE_W-1:0]   hi,
  input  logic [BYTE_W-1:0]   lo,
  input  logic                half,
  input  logic                paired,
  input  logic                ready,
  output logic                can_load,
  output logic                pair_acc,
  output logic                valid,
  output logic [2*BYTE_W-1:0] data,
  output logic                data_half
);

  logic                valid_q, valid_d;
  logic [2*BYTE_W-1:0] data_q;
  logic                half_q;
  logic                paired_q;

  always_comb begin
    if (load) begin
      valid_d = 1'b1;
    end else if (valid_q && ready) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      half_q   <= 1'b0;
      paired_q <= 1'b0;
    end else if (load) begin
      data_q   <= {hi, lo};
      half_q   <= half;
      paired_q <= paired;
    end
  end

  assign can_load  = !valid_q || ready;
  assign pair_acc  = valid_q && ready && paired_q;
  assign valid     = valid_q;
  assign data      = data_q;
  assign data_half = half_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(data_q) && $stable(half_q))) else $error("AST_OUT_HOLD"); // R10

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid_q || ready)) else $error("AST_NO_OVERWRITE"); // R10

  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && half_q) |-> (data_q[2*BYTE_W-1:BYTE_W] == '0)) else $error("AST_HALF_UPPER_ZERO"); // R4

endmodule

// File: rtl/wide_pair_send.sv
module wide_pair_send
  import wps_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_start,
  input  logic [CNT_W-1:0]    xfer_count,
  input  logic                xfer_chained,
  output logic                xfer_busy,
  input  logic [BYTE_W-1:0]   in_data,
  input  logic                in_valid,
  output logic                in_ready,
  output logic [2*BYTE_W-1:0] out_data,
  output logic                out_half,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                pend_flag,
  input  logic                pend_clr
);

  logic              rst_n_i;
  logic              rem_zero, rem_last, chained;
  logic              cnt_load, fire;
  logic              can_load, pair_acc;
  emit_e             emit;
  logic [BYTE_W-1:0] word_hi, word_lo;
  logic              word_paired;

  wps_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign xfer_busy = !rem_zero || out_valid;
  assign cnt_load  = xfer_start && !xfer_busy && (xfer_count != '0);
  assign in_ready  = !rem_zero && can_load;
  assign fire      = in_valid && in_ready;

  wps_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .load         (cnt_load),
    .load_cnt     (xfer_count),
    .load_chained (xfer_chained),
    .dec          (fire),
    .rem_zero     (rem_zero),
    .rem_last     (rem_last),
    .chained      (chained)
  );

  wps_pair_unit #(.BYTE_W(BYTE_W)) u_pair (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .fire        (fire),
    .in_byte     (in_data),
    .last_byte   (rem_last),
    .chained     (chained),
    .sw_clr      (pend_clr),
    .pair_acc    (pair_acc),
    .emit        (emit),
    .word_hi     (word_hi),
    .word_lo     (word_lo),
    .word_paired (word_paired),
    .pend        (pend_flag)
  );

  wps_word_reg #(.BYTE_W(BYTE_W)) u_word (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (emit != EMIT_NONE),
    .hi        (word_hi),
    .lo        (word_lo),
    .half      (emit == EMIT_HALF),
    .paired    (word_paired),
    .ready     (out_ready),
    .can_load  (can_load),
    .pair_acc  (pair_acc),
    .valid     (out_valid),
    .data      (out_data),
    .data_half (out_half)
  );

  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n_i)
    !xfer_busy |-> !in_ready) else $error("AST_IDLE_NOT_READY"); // R3

  AST_PEND_DROPS_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pair_acc && !pend_clr && !(fire && rem_last && chained)) |=> !pend_flag) else $error("AST_PEND_DROPS_ON_PAIR"); // R8

endmodule

// File: tb/wide_pair_send_tb_top.sv
module wide_pair_send_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xs = 1'b0;
  logic [11:0] xc = '0;
  logic        xch = 1'b0;
  logic        busy;
  logic [7:0]  id = '0;
  logic        iv = 1'b0;
  logic        irdy;
  logic [15:0] od;
  logic        ohalf;
  logic        ov;
  logic        ordy = 1'b0;
  logic        pflag;
  logic        clr = 1'b0;

  always #4 clk = ~clk;

  wide_pair_send dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_start   (xs),
    .xfer_count   (xc),
    .xfer_chained (xch),
    .xfer_busy    (busy),
    .in_data      (id),
    .in_valid     (iv),
    .in_ready     (irdy),
    .out_data     (od),
    .out_half     (ohalf),
    .out_valid    (ov),
    .out_ready    (ordy),
    .pend_flag    (pflag),
    .pend_clr     (clr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit running = 1'b0;
  int src_pct = 100;
  int rdy_pct = 100;

  logic [7:0]  srcq[$];
  logic [16:0] got_q[$];
  logic [16:0] exp_q[$];
  logic [7:0]  bytes[$];

  // behavioural reference model, updated on the same edge as the design
  int          m_rem;
  bit          m_chn;
  bit          m_ov, m_half, m_pair, m_have, m_pend;
  logic [15:0] m_od;
  logic [7:0]  m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_chn = 0; m_ov = 0; m_half = 0; m_pair = 0;
      m_have = 0; m_pend = 0; m_od = '0; m_hold = '0;
    end else begin
      bit b_busy, b_rdy, b_fire, b_set, n_have, n_pend;
      b_busy = (m_rem != 0) || m_ov;
      b_rdy  = (m_rem != 0) && (!m_ov || ordy);
      b_fire = iv && b_rdy;
      b_set  = 0;
      n_have = m_have;
      n_pend = m_pend;
      if (m_ov && ordy) begin
        m_ov = 0;
        if (m_pair) n_pend = 0;
      end
      if (b_fire) begin
        if (m_have) begin
          m_ov = 1; m_od = {id, m_hold}; m_half = 0; m_pair = m_pend; n_have = 0;
        end else if (m_rem == 1 && m_chn) begin
          b_set = 1; n_have = 1; m_hold = id;
        end else if (m_rem == 1) begin
          m_ov = 1; m_od = {8'h00, id}; m_half = 1; m_pair = 0;
        end else begin
          n_have = 1; m_hold = id;
        end
        m_rem = m_rem - 1;
        void'(srcq.pop_front());
      end
      if (b_set) n_pend = 1;
      if (clr) begin
        n_pend = 0;
        if (b_set || (m_pend && m_have)) n_have = 0;
      end
      m_have = n_have;
      m_pend = n_pend;
      if (xs && !b_busy && xc != 0) begin
        m_rem = int'(xc);
        m_chn = xch;
      end
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  bit          p_ov = 0;
  logic [15:0] p_od = '0;
  bit          p_half = 0;

  always @(posedge clk) begin
    #2;
    if (running) begin
      check_eq("R3 in_ready", int'(irdy), int'((m_rem != 0) && (!m_ov || ordy)));
      check_eq("R3 xfer_busy", int'(busy), int'((m_rem != 0) || m_ov));
      check_eq("R2 out_valid", int'(ov), int'(m_ov));
      if (m_ov) begin
        check_eq("R2 R7 out_data", int'(od), int'(m_od));
        check_eq("R4 out_half", int'(ohalf), int'(m_half));
      end
      check_eq("R5 R6 R8 pend_flag", int'(pflag), int'(m_pend));
      if (p_ov && !ordy) begin
        check_eq("R10 held valid", int'(ov), 1);
        check_eq("R10 held data", int'({ohalf, od}), int'({p_half, p_od}));
      end
      if (p_ov && ordy) got_q.push_back({p_half, p_od});
    end
    p_ov = ov; p_od = od; p_half = ohalf;
  end

  always @(negedge clk) begin
    iv   <= (srcq.size() > 0) && (($urandom % 100) < src_pct);
    id   <= (srcq.size() > 0) ? srcq[0] : 8'h00;
    ordy <= (($urandom % 100) < rdy_pct);
  end

  task automatic wait_idle();
    @(negedge clk);
    while (m_rem != 0 || m_ov) @(negedge clk);
  endtask

  task automatic xfer(input int n, input bit ch);
    wait_idle();
    bytes.delete();
    for (int k = 0; k < n; k++) begin
      bytes.push_back(8'($urandom));
      srcq.push_back(bytes[k]);
    end
    xs = 1; xc = 12'(n); xch = ch;
    @(negedge clk);
    xs = 0;
    wait_idle();
  endtask

  task automatic sw_clear();
    wait_idle();
    clr = 1;
    @(negedge clk);
    clr = 0;
    @(negedge clk);
  endtask

  task automatic cmp_words(input string tag);
    check_eq({tag, " word count"}, got_q.size(), exp_q.size());
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      check_eq(tag, int'(got_q[k]), int'(exp_q[k]));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  logic [7:0] held;
  logic [7:0] keep0;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 pend_flag in reset", int'(pflag), 0);
    check_eq("R1 out_valid in reset", int'(ov), 0);
    check_eq("R1 in_ready in reset", int'(irdy), 0);
    check_eq("R1 busy in reset", int'(busy), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_eq("R1 pend_flag after reset", int'(pflag), 0);
    check_eq("R1 in_ready after reset", int'(irdy), 0);
    running = 1;

    // R2: plain even move
    xfer(6, 0);
    exp_q.push_back({1'b0, bytes[1], bytes[0]});
    exp_q.push_back({1'b0, bytes[3], bytes[2]});
    exp_q.push_back({1'b0, bytes[5], bytes[4]});
    cmp_words("R2 pair order");

    // R4 / R6: plain odd move
    rdy_pct = 30;
    xfer(5, 0);
    exp_q.push_back({1'b0, bytes[1], bytes[0]});
    exp_q.push_back({1'b0, bytes[3], bytes[2]});
    exp_q.push_back({1'b1, 8'h00, bytes[4]});
    cmp_words("R4 half word");
    check_eq("R6 no flag after plain odd", int'(pflag), 0);

    // R5: chained odd move parks last byte
    rdy_pct = 100;
    xfer(3, 1);
    held = bytes[2];
    exp_q.push_back({1'b0, bytes[1], bytes[0]});
    cmp_words("R5 chained odd words");
    check_eq("R5 flag set", int'(pflag), 1);

    // R11: zero count leaves everything alone
    xfer(0, 0);
    cmp_words("R11 no word");
    check_eq("R11 flag kept", int'(pflag), 1);

    // R7 / R8: plain move marries the parked byte
    rdy_pct = 40;
    xfer(2, 0);
    exp_q.push_back({1'b0, bytes[0], held});
    exp_q.push_back({1'b1, 8'h00, bytes[1]});
    cmp_words("R7 married word plain");
    check_eq("R8 flag cleared", int'(pflag), 0);
    check_eq("R7 count includes paired byte", srcq.size(), 0);

    // R7 chained follow-up re-parks, then R9 software clear
    rdy_pct = 100;
    xfer(1, 1);
    held = bytes[0];
    check_eq("R5 single chained byte", int'(pflag), 1);
    xfer(2, 1);
    exp_q.push_back({1'b0, bytes[0], held});
    cmp_words("R7 married word chained");
    check_eq("R7 flag set again", int'(pflag), 1);
    sw_clear();
    check_eq("R9 flag cleared by software", int'(pflag), 0);
    xfer(2, 0);
    exp_q.push_back({1'b0, bytes[1], bytes[0]});
    cmp_words("R9 fresh alignment");

    // R3: start while busy is ignored
    rdy_pct = 10;
    wait_idle();
    bytes.delete();
    for (int k = 0; k < 4; k++) begin
      bytes.push_back(8'($urandom));
      srcq.push_back(bytes[k]);
    end
    keep0 = bytes[0];
    xs = 1; xc = 12'd4; xch = 0;
    @(negedge clk);
    xs = 1; xc = 12'd3; xch = 1;
    @(negedge clk);
    xs = 0;
    wait_idle();
    exp_q.push_back({1'b0, bytes[1], keep0});
    exp_q.push_back({1'b0, bytes[3], bytes[2]});
    cmp_words("R3 busy start ignored");
    check_eq("R3 source drained", srcq.size(), 0);
    check_eq("R3 no flag from ignored start", int'(pflag), 0);

    // randomized phase, checked by the model each cycle
    for (int t = 0; t < 60; t++) begin
      rdy_pct = 20 + int'($urandom % 81);
      src_pct = 30 + int'($urandom % 71);
      if (($urandom % 6) == 0) sw_clear();
      xfer(int'($urandom % 10), 1'($urandom));
    end
    wait_idle();
    check_eq("R3 final source drained", srcq.size(), 0);

    running = 0;
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule